// File: doc/BRIEF.md
# Field Parity Detector and Parameter-Set Selector

This block works out whether the current video field is odd or even from a horizontal and a vertical sync signal, both synchronous to the block clock. At a chosen edge of the vertical signal it samples the level of the horizontal signal. It turns that sample into a field flag under one of three detection policies: direct, stabilised or forced toggle.

The field flag then drives a select line for two banks of processing parameters, set A (select 0) and set B (select 1). A scaler can therefore use one parameter bank on odd fields and the other on even fields. The mapping can pass the flag through, invert it, or pin the select to either bank. Both outputs change only on the clock edge that registers a vertical reference edge, so a bank never switches part-way through a field.

The stabilised policy uses a two-state machine. In HUNT, the flag free-runs by inverting on every reference edge. Each reference edge whose H sample differs from the previous sample extends an alternation run. When the run reaches the programmed lock length, the transition HUNT->LOCKED resynchronises the flag to the sample. In LOCKED, the transition LOCKED->LOCKED follows the sample while alternation holds. A repeated sample takes the transition LOCKED->HUNT, clears the run and resumes free-running.

Top module: `fdet_field_select`

## Requirements
- R1: During and after reset, before any vertical reference edge, field_flag and set_sel are 0 and the stabiliser is in HUNT with an empty run.
- R2: With cfg_v_fall = 0 the reference edge is a 0->1 change of v_in; with cfg_v_fall = 1 it is a 1->0 change. The opposite change of v_in leaves both outputs unchanged.
- R3: The H sample is h_in XOR cfg_h_inv, taken in the clock cycle that registers the reference edge.
- R4: With cfg_det_mode = 00 (normal), or the reserved code 11, field_flag takes the H sample at every reference edge.
- R5: With cfg_det_mode = 10 (forced toggle), field_flag inverts at every reference edge whatever h_in is.
- R6: With cfg_det_mode = 01 (stabilised) in HUNT, field_flag inverts at each reference edge. A reference edge whose sample differs from the previous reference edge's sample (in any mode) adds one to the run, which saturates at 2^CNT_W-1.
- R7: In stabilised mode, the reference edge at which the run reaches cfg_lock_len (0 counts as 1) enters LOCKED and loads the sample into field_flag. While in LOCKED, alternating samples keep loading the sample into field_flag.
- R8: In stabilised mode, a sample equal to the previous one clears the run, returns to HUNT and inverts field_flag. Any reference edge taken in another mode also clears the run and returns to HUNT.
- R9: The set_sel value loaded at a reference edge is set by cfg_map_mode: 00 gives the new field_flag, 01 its inverse, 10 a constant 0 (set A), 11 a constant 1 (set B).
- R10: field_flag and set_sel change only on a clock edge that registers a reference edge. Configuration changes between reference edges have no effect on them until the next such edge.
- R11: A reference edge present at v_in at clock edge k, relative to the v_in level registered at edge k-1, updates both outputs at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_in | input | 1 | Horizontal sync level, synchronous to clk |
| v_in | input | 1 | Vertical sync level, synchronous to clk |
| cfg_v_fall | input | 1 | 0: rising edge of v_in is the reference; 1: falling edge |
| cfg_h_inv | input | 1 | Inverts the sampled H level |
| cfg_det_mode | input | 2 | 00 normal, 01 stabilised, 10 forced toggle, 11 as normal |
| cfg_map_mode | input | 2 | 00 field, 01 inverted field, 10 set A, 11 set B |
| cfg_lock_len | input | CNT_W | Alternating edges needed to lock (0 acts as 1) |
| field_flag | output | 1 | Recovered field identity |
| set_sel | output | 1 | Parameter bank select, 0 = set A, 1 = set B |

## Verification
A wrong stabiliser state or run count shows as field_flag taking the free-running inverse instead of the H sample, or the sample instead of the inverse. It appears at the first reference edge where the two differ, which is the very next edge once lock should or should not have happened. A wrong edge or polarity choice corrupts field_flag in the cycle after the offending v_in change. A mapping fault shows on set_sel at the same edge, while a bank switch outside a reference edge shows in the cycle after a configuration write. The directed scenarios pair each reference edge with samples chosen so that each of these faults flips at least one output.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    typedef enum logic [1:0] {
        DET_NORMAL = 2'b00,
        DET_STABLE = 2'b01,
        DET_TOGGLE = 2'b10,
        DET_RSVD   = 2'b11
    } det_mode_e;

    typedef enum logic [1:0] {
        MAP_FIELD  = 2'b00,
        MAP_INVERT = 2'b01,
        MAP_SET_A  = 2'b10,
        MAP_SET_B  = 2'b11
    } map_mode_e;

    typedef enum logic {
        LK_HUNT   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/fdet_edge.sv
module fdet_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic v_in,
    input  logic h_in,
    input  logic cfg_v_fall,
    input  logic cfg_h_inv,
    output logic ref_hit,
    output logic h_smp
);
    logic v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    always_comb begin
        ref_hit = cfg_v_fall ? (v_q & ~v_in) : (~v_q & v_in);
        h_smp   = h_in ^ cfg_h_inv;
    end

    // A reference edge is always followed by a non-reference cycle (R2)
    assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && $stable(cfg_v_fall)) |=> !ref_hit || $changed(cfg_v_fall));

endmodule

// File: rtl/fdet_lock_fsm.sv
module fdet_lock_fsm
    import fdet_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_hit,
    input  logic             h_smp,
    input  logic             stab_en,
    input  logic             cur_field,
    input  logic [CNT_W-1:0] lock_len,
    output logic             stab_field,
    output logic             locked
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic             prev_q, have_q;
    logic             alt;
    logic [CNT_W-1:0] lock_eff;

    always_comb begin
        alt      = have_q && (h_smp != prev_q);
        lock_eff = (lock_len == '0) ? CNT_ONE : lock_len;
        if (!alt)                run_d = '0;
        else if (run_q == CNT_MAX) run_d = run_q;
        else                     run_d = run_q + CNT_ONE;
    end

    // next state and output process
    always_comb begin
        state_d    = state_q;
        stab_field = ~cur_field;
        unique case (state_q)
            LK_HUNT: begin
                if (run_d >= lock_eff) begin
                    state_d    = LK_LOCKED;   // HUNT->LOCKED
                    stab_field = h_smp;
                end
            end
            LK_LOCKED: begin
                if (alt) begin
                    state_d    = LK_LOCKED;   // LOCKED->LOCKED
                    stab_field = h_smp;
                end else begin
                    state_d    = LK_HUNT;     // LOCKED->HUNT
                end
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_HUNT;
            run_q   <= '0;
            prev_q  <= 1'b0;
            have_q  <= 1'b0;
        end else if (ref_hit) begin
            prev_q <= h_smp;
            have_q <= 1'b1;
            if (stab_en) begin
                state_q <= state_d;
                run_q   <= run_d;
            end else begin
                state_q <= LK_HUNT;
                run_q   <= '0;
            end
        end
    end

    assign locked = (state_q == LK_LOCKED);

    // A repeated sample in stabilised mode always leaves the machine hunting (R8)
    assert_break_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && stab_en && have_q && (h_smp == prev_q)) |=> !locked);

    // Lock can only be gained at a reference edge (R7)
    assert_lock_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_hit |=> $stable(locked));

endmodule

// File: rtl/fdet_map.sv
module fdet_map
    import fdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_hit,
    input  logic       field_nxt,
    input  logic [1:0] cfg_map_mode,
    output logic       set_sel
);
    map_mode_e map_mode;
    logic      sel_d;

    always_comb begin
        map_mode = map_mode_e'(cfg_map_mode);
        unique case (map_mode)
            MAP_FIELD:  sel_d = field_nxt;
            MAP_INVERT: sel_d = ~field_nxt;
            MAP_SET_A:  sel_d = 1'b0;
            MAP_SET_B:  sel_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       set_sel <= 1'b0;
        else if (ref_hit) set_sel <= sel_d;
    end

    assert_force_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && cfg_map_mode == 2'b10) |=> !set_sel);

    assert_follow_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && cfg_map_mode == 2'b00) |=> set_sel == $past(field_nxt));

endmodule

// File: rtl/fdet_field_select.sv
module fdet_field_select
    import fdet_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_in,
    input  logic             v_in,
    input  logic             cfg_v_fall,
    input  logic             cfg_h_inv,
    input  logic [1:0]       cfg_det_mode,
    input  logic [1:0]       cfg_map_mode,
    input  logic [CNT_W-1:0] cfg_lock_len,
    output logic             field_flag,
    output logic             set_sel
);
    det_mode_e det_mode;
    logic      ref_hit, h_smp;
    logic      stab_field, locked;
    logic      field_nxt;

    assign det_mode = det_mode_e'(cfg_det_mode);

    fdet_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .v_in       (v_in),
        .h_in       (h_in),
        .cfg_v_fall (cfg_v_fall),
        .cfg_h_inv  (cfg_h_inv),
        .ref_hit    (ref_hit),
        .h_smp      (h_smp)
    );

    fdet_lock_fsm #(.CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_hit    (ref_hit),
        .h_smp      (h_smp),
        .stab_en    (det_mode == DET_STABLE),
        .cur_field  (field_flag),
        .lock_len   (cfg_lock_len),
        .stab_field (stab_field),
        .locked     (locked)
    );

    always_comb begin
        unique case (det_mode)
            DET_NORMAL: field_nxt = h_smp;
            DET_STABLE: field_nxt = stab_field;
            DET_TOGGLE: field_nxt = ~field_flag;
            DET_RSVD:   field_nxt = h_smp;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       field_flag <= 1'b0;
        else if (ref_hit) field_flag <= field_nxt;
    end

    fdet_map u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_hit      (ref_hit),
        .field_nxt    (field_nxt),
        .cfg_map_mode (cfg_map_mode),
        .set_sel      (set_sel)
    );

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_hit |=> ($stable(field_flag) && $stable(set_sel)));

    assert_normal_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && (cfg_det_mode == 2'b00 || cfg_det_mode == 2'b11))
        |=> field_flag == $past(h_smp));

    assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && cfg_det_mode == 2'b10) |=> field_flag != $past(field_flag));

    assert_locked_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && cfg_det_mode == 2'b01) |=> (!locked || field_flag == $past(h_smp)));

endmodule

// File: tb/tb_fdet_field_select.sv
module tb_fdet_field_select;
    localparam int CNT_W = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_in = 1'b0, v_in = 1'b0;
    logic cfg_v_fall = 1'b0, cfg_h_inv = 1'b0;
    logic [1:0] cfg_det_mode = 2'b00, cfg_map_mode = 2'b00;
    logic [CNT_W-1:0] cfg_lock_len = CNT_W'(4);
    logic field_flag, set_sel;

    int checks = 0, fails = 0;
    bit done = 0;

    // spec model state
    bit m_f = 0, m_s = 0, m_lock = 0, m_prev = 0, m_have = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    fdet_field_select #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .h_in(h_in), .v_in(v_in),
        .cfg_v_fall(cfg_v_fall), .cfg_h_inv(cfg_h_inv),
        .cfg_det_mode(cfg_det_mode), .cfg_map_mode(cfg_map_mode),
        .cfg_lock_len(cfg_lock_len), .field_flag(field_flag), .set_sel(set_sel)
    );

    task automatic chk(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic model_ref(input bit h);
        bit hs, alt;
        int nc, lle;
        hs = h ^ cfg_h_inv;
        if (cfg_det_mode == 2'b01) begin
            alt = m_have && (hs != m_prev);
            nc  = alt ? ((m_cnt == CNT_MAX) ? m_cnt : m_cnt + 1) : 0;
            lle = (cfg_lock_len == 0) ? 1 : int'(cfg_lock_len);
            if (!m_lock) begin
                if (nc >= lle) begin m_lock = 1; m_f = hs; end
                else m_f = ~m_f;
            end else if (alt) m_f = hs;
            else begin m_lock = 0; m_f = ~m_f; end
            m_cnt = nc;
        end else begin
            if (cfg_det_mode == 2'b10) m_f = ~m_f;
            else m_f = hs;
            m_cnt = 0; m_lock = 0;
        end
        m_prev = hs; m_have = 1;
        case (cfg_map_mode)
            2'b00: m_s = m_f;
            2'b01: m_s = ~m_f;
            2'b10: m_s = 0;
            default: m_s = 1;
        endcase
    endtask

    // flip v_in with H level h; check both outputs after the registering edge
    task automatic v_flip(input bit h, input string req);
        bit is_ref;
        @(negedge clk);
        h_in = h;
        v_in = ~v_in;
        is_ref = cfg_v_fall ? (v_in == 1'b0) : (v_in == 1'b1);
        @(posedge clk);
        @(negedge clk);
        if (is_ref) model_ref(h);
        chk(req, "field_flag", field_flag, m_f);
        chk(req, "set_sel", set_sel, m_s);
    endtask

    task automatic pulse(input bit h, input string req);
        v_flip(h, req);
        v_flip(h, req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "field_flag in reset", field_flag, 1'b0);
        chk("R1", "set_sel in reset", set_sel, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "field_flag after reset", field_flag, 1'b0);
        chk("R1", "set_sel after reset", set_sel, 1'b0);
    endtask

    task automatic t_normal();
        cfg_det_mode = 2'b00; cfg_map_mode = 2'b00;
        pulse(1, "R4"); pulse(0, "R11"); pulse(0, "R4"); pulse(1, "R4");
    endtask

    task automatic t_polarity();
        cfg_h_inv = 1'b1;
        pulse(1, "R3"); pulse(0, "R3"); pulse(1, "R3");
        cfg_h_inv = 1'b0;
    endtask

    task automatic t_edge_sel();
        cfg_v_fall = 1'b1;
        pulse(0, "R2");  // rising then falling: only the falling flip updates
        v_flip(1, "R2"); // rising edge with H high: ignored
        chk("R2", "non-reference edge ignored", field_flag, 1'b0);
        v_flip(1, "R2"); // falling edge loads 1
        chk("R2", "falling reference loads", field_flag, 1'b1);
        cfg_v_fall = 1'b0;
    endtask

    task automatic t_toggle();
        cfg_det_mode = 2'b10;
        pulse(1, "R5"); pulse(1, "R5"); pulse(0, "R5"); pulse(0, "R5");
    endtask

    task automatic t_reserved();
        cfg_det_mode = 2'b11;
        pulse(1, "R4"); pulse(0, "R4"); pulse(0, "R4");
    endtask

    task automatic t_stab_lock();
        bit h;
        cfg_det_mode = 2'b01; cfg_lock_len = CNT_W'(4);
        pulse(0, "R6"); // first stabilised edge after repeats: hunting
        h = 0;
        for (int i = 0; i < 8; i++) begin
            h = ~h;
            pulse(h, (i < 4) ? "R6" : "R7");
        end
    endtask

    task automatic t_stab_break();
        pulse(0, "R8"); // sample repeats previous (last was 0)
        pulse(0, "R8");
        pulse(1, "R8");
        pulse(0, "R8");
        cfg_lock_len = '0;  // zero acts as one
        pulse(1, "R7");
        pulse(0, "R7");
        cfg_lock_len = CNT_W'(4);
    endtask

    task automatic t_map();
        cfg_det_mode = 2'b00;
        for (int m = 0; m < 4; m++) begin
            cfg_map_mode = 2'(m);
            pulse(0, "R9"); pulse(1, "R9");
        end
        cfg_map_mode = 2'b00;
    endtask

    task automatic t_hold();
        bit f0, s0;
        cfg_det_mode = 2'b00;
        pulse(1, "R10");
        f0 = field_flag; s0 = set_sel;
        @(negedge clk);
        cfg_map_mode = 2'b01; cfg_det_mode = 2'b10; h_in = 1'b0; cfg_h_inv = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "field held between edges", field_flag, f0);
        chk("R10", "set_sel held between edges", set_sel, s0);
        cfg_h_inv = 1'b0;
        pulse(0, "R10");
        cfg_map_mode = 2'b00; cfg_det_mode = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal();
        t_polarity();
        t_edge_sel();
        t_toggle();
        t_reserved();
        t_stab_lock();
        t_stab_break();
        t_map();
        t_hold();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule